// File: doc/BRIEF.md
# Parallel FIR Bank with Filter-Level Single-Error Correction

Four data lanes are each filtered by an identical 4-tap FIR filter. Three extra filters with the same response run on sums of three of the four input lanes. Because filtering is linear, each extra filter's output must equal the sum of the matching data-filter outputs. The three extra outputs therefore act as the parity symbols of a single-error-correcting Hamming code. The code symbols are whole filter outputs, not bits.

Each output cycle the block makes three parity checks and packs them into a 3-bit syndrome. The syndrome names the one faulty filter, which may be a data filter or a parity filter. If a data filter is faulty, its output is rebuilt from a parity output and the two other data outputs in that check. The corrected lanes are delivered together with a per-sample error flag, a sticky error flag and the syndrome.

A test port XORs a chosen mask into the registered output of one selected filter. This lets every single-filter fault be produced on purpose.

Top module: `par_fir_guard`

## Requirements
- R1: With no fault injected, lane c of `out_data` (bits c*20 +: 20, two's complement) equals y[n] = 127*x[n] - 128*x[n-1] + 64*x[n-2] - 1*x[n-3]. Here x is lane c of `in_data` (bits c*8 +: 8, signed), and samples before reset count as zero.
- R2: The filter history advances only on cycles with `in_valid` high. Idle cycles neither shift the history nor change `out_data`.
- R3: No intermediate sum overflows. Inputs at full scale (all -128, all 127, alternating) give the exact R1 result in 20 bits.
- R4: Syndrome bit 0 is set when parity output 1 (input lane0+lane1+lane2) differs from the sum of data outputs 0, 1 and 2. Bit 1 does the same for lanes 0, 1, 3, and bit 2 for lanes 0, 2, 3. With no fault the syndrome is 000 and `out_err` is low.
- R5: A nonzero mask on data filter `flt_sel` = 0, 1, 2 or 3 gives syndrome 111, 011, 101 or 110 respectively. `out_err` goes high and all four lanes still show the R1 values.
- R6: A nonzero mask on parity filter `flt_sel` = 4, 5 or 6 gives syndrome 001, 010 or 100. The data lanes are unchanged. `flt_sel` = 7 selects no filter and has no effect.
- R7: `err_sticky` is set by the first output that carries a nonzero syndrome. It stays set after faults stop, while `out_err` returns low, and it is cleared only by reset.
- R8: During and just after reset, `out_valid`, `out_data`, `out_err`, `err_sticky` and `syndrome` are all zero.
- R9: `out_valid` is high exactly two cycles after each cycle with `in_valid` high, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new sample set is present on `in_data` |
| in_data | input | 32 | Four signed 8-bit input samples, lane c at bits c*8 +: 8 |
| flt_sel | input | 3 | Filter that receives the fault mask (0-3 data, 4-6 parity, 7 none) |
| flt_mask | input | 20 | Value XORed into the selected filter's output |
| out_valid | output | 1 | Corrected lanes and status are valid |
| out_data | output | 80 | Four corrected signed 20-bit outputs, lane c at bits c*20 +: 20 |
| out_err | output | 1 | The current output carried a nonzero syndrome |
| err_sticky | output | 1 | A nonzero syndrome has been seen since reset |
| syndrome | output | 3 | Failed-check pattern for the current output |

## Verification
The hardest case to reach from the ports is a fault in exactly one filter, and in particular a fault in a single high-order output bit that only wraps the arithmetic. Real faults never show up at the pins. The bench therefore holds `flt_sel` and `flt_mask` steady over whole bursts of samples. It walks all seven filters with a low-bit mask, a top-bit mask and a mixed mask. The lanes are compared against a bench-side FIR model that knows nothing of the parity filters. This shows that the rebuilt lane is the true value and not merely a consistent one.

// File: rtl/par_fir_guard.sv
module par_fir_guard #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] COEF = {8'hFF, 8'h40, 8'h80, 8'h7F},
  localparam int NCH = 4,
  localparam int NFLT = 7,
  localparam int IW = DW + 2,
  localparam int OW = IW + CW + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_data,
  input  logic [2:0]        flt_sel,
  input  logic [OW-1:0]     flt_mask,
  output logic              out_valid,
  output logic [NCH*OW-1:0] out_data,
  output logic              out_err,
  output logic              err_sticky,
  output logic [2:0]        syndrome
);

  logic signed [IW-1:0] xin [NCH];
  logic signed [IW-1:0] pin [3];
  logic [OW-1:0]        yv  [NFLT];
  logic [OW-1:0]        fx  [NCH];
  logic [2:0]           syn;
  logic                 v1;

  for (genvar c = 0; c < NCH; c++) begin : g_in
    assign xin[c] = IW'($signed(in_data[c*DW +: DW]));
  end

  assign pin[0] = xin[0] + xin[1] + xin[2];
  assign pin[1] = xin[0] + xin[1] + xin[3];
  assign pin[2] = xin[0] + xin[2] + xin[3];

  for (genvar f = 0; f < NFLT; f++) begin : g_flt
    logic signed [IW-1:0] cur;
    logic signed [IW-1:0] dl [TAPS-1];
    logic signed [OW-1:0] acc;
    logic [OW-1:0]        yr;

    if (f < NCH) begin : g_dat
      assign cur = xin[f];
    end else begin : g_par
      assign cur = pin[f-NCH];
    end

    always_comb begin
      acc = OW'(cur) * OW'($signed(COEF[CW-1:0]));
      for (int k = 1; k < TAPS; k++)
        acc = acc + OW'(dl[k-1]) * OW'($signed(COEF[k*CW +: CW]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < TAPS-1; k++) dl[k] <= '0;
        yr <= '0;
      end else if (in_valid) begin
        dl[0] <= cur;
        for (int k = 1; k < TAPS-1; k++) dl[k] <= dl[k-1];
        yr <= acc;
      end
    end

    assign yv[f] = yr ^ ((flt_sel == 3'(f)) ? flt_mask : '0);
  end

  assign syn[0] = yv[4] != yv[0] + yv[1] + yv[2];
  assign syn[1] = yv[5] != yv[0] + yv[1] + yv[3];
  assign syn[2] = yv[6] != yv[0] + yv[2] + yv[3];

  always_comb begin
    for (int c = 0; c < NCH; c++) fx[c] = yv[c];
    case (syn)
      3'b111:  fx[0] = yv[4] - yv[1] - yv[2];
      3'b011:  fx[1] = yv[4] - yv[0] - yv[2];
      3'b101:  fx[2] = yv[4] - yv[0] - yv[1];
      3'b110:  fx[3] = yv[5] - yv[0] - yv[1];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1         <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_err    <= 1'b0;
      err_sticky <= 1'b0;
      syndrome   <= '0;
    end else begin
      v1        <= in_valid;
      out_valid <= v1;
      if (v1) begin
        for (int c = 0; c < NCH; c++) out_data[c*OW +: OW] <= fx[c];
        syndrome   <= syn;
        out_err    <= |syn;
        err_sticky <= err_sticky | (|syn);
      end
    end
  end

endmodule

// File: rtl/par_fir_guard_chk.sv
module par_fir_guard_chk #(
  parameter int OW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [2:0]    flt_sel,
  input logic [OW-1:0] flt_mask,
  input logic          out_valid,
  input logic          out_err,
  input logic          err_sticky,
  input logic [2:0]    syndrome
);

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> ##1 out_valid); // R9
  AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ##1 !out_valid); // R9
  AST_CLEAN_SYN: assert property (@(posedge clk) disable iff (!rst_n) in_valid ##1 (flt_mask == '0) |=> (syndrome == 3'b000 && !out_err)); // R4
  AST_DATA_FAULT: assert property (@(posedge clk) disable iff (!rst_n) in_valid ##1 (flt_sel < 3'd4 && flt_mask != '0) |=> ($countones(syndrome) >= 2 && out_err)); // R5
  AST_PAR_FAULT: assert property (@(posedge clk) disable iff (!rst_n) in_valid ##1 (flt_sel >= 3'd4 && flt_sel != 3'd7 && flt_mask != '0) |=> ($countones(syndrome) == 1)); // R6
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) err_sticky |=> err_sticky); // R7

endmodule

bind par_fir_guard par_fir_guard_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .flt_sel(flt_sel), .flt_mask(flt_mask),
  .out_valid(out_valid), .out_err(out_err), .err_sticky(err_sticky), .syndrome(syndrome)
);

// File: tb/tb_par_fir_guard.sv
module tb_par_fir_guard;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int OW = 20;
  localparam int CF [4] = '{127, -128, 64, -1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [4*DW-1:0] in_data = '0;
  logic [2:0]    flt_sel = 3'd7;
  logic [OW-1:0] flt_mask = '0;
  logic          out_valid, out_err, err_sticky;
  logic [4*OW-1:0] out_data;
  logic [2:0]    syndrome;

  par_fir_guard dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .flt_sel(flt_sel), .flt_mask(flt_mask), .out_valid(out_valid),
    .out_data(out_data), .out_err(out_err), .err_sticky(err_sticky), .syndrome(syndrome)
  );

  always #(CLK_P/2) clk = ~clk;

  int hist [4][4];
  logic [4*OW-1:0] q_y [$];
  logic [2:0]      q_s [$];
  int n_chk = 0, n_bad = 0, seed = 7;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [4*OW-1:0] act, input logic [4*OW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_syn(input logic [2:0] s, input logic [OW-1:0] m);
    if (m == '0) return 3'b000;
    case (s)
      3'd0: return 3'b111;
      3'd1: return 3'b011;
      3'd2: return 3'b101;
      3'd3: return 3'b110;
      3'd4: return 3'b001;
      3'd5: return 3'b010;
      3'd6: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int rnd8();
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 16) & 255) - 128;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done && out_valid) begin
      if (q_y.size() == 0) begin
        chk(1'b0, "R9", "valid without sample", {79'd0, out_valid}, '0);
      end else begin
        logic [4*OW-1:0] ey;
        logic [2:0] es;
        ey = q_y.pop_front();
        es = q_s.pop_front();
        chk(out_data === ey, cur_req, "lanes", out_data, ey);
        chk(syndrome === es && out_err === (es != 0), cur_req, "syndrome",
            {76'd0, out_err, syndrome}, {76'd0, es != 0, es});
      end
    end
  end

  task automatic drive(input int a, input int b, input int c, input int d);
    int v [4];
    logic [4*OW-1:0] ey;
    v = '{a, b, c, d};
    @(negedge clk);
    in_valid = 1'b1;
    for (int ch = 0; ch < 4; ch++) begin
      int y;
      in_data[ch*DW +: DW] = v[ch][7:0];
      for (int k = 3; k > 0; k--) hist[ch][k] = hist[ch][k-1];
      hist[ch][0] = v[ch];
      y = 0;
      for (int k = 0; k < 4; k++) y += CF[k] * hist[ch][k];
      ey[ch*OW +: OW] = OW'(y);
    end
    q_y.push_back(ey);
    q_s.push_back(exp_syn(flt_sel, flt_mask));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(4);
    chk(q_y.size() == 0, "R9", "outputs missing", 80'(q_y.size()), '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    q_y.delete();
    q_s.delete();
    for (int ch = 0; ch < 4; ch++)
      for (int k = 0; k < 4; k++) hist[ch][k] = 0;
    idle(2);
    chk(out_valid == 0 && out_data == '0 && err_sticky == 0 && out_err == 0 && syndrome == 0,
        "R8", "state in reset", {out_valid, out_err, err_sticky, syndrome, out_data[72:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_data == '0 && err_sticky == 0 && out_err == 0 && syndrome == 0,
        "R8", "state after reset", {out_valid, out_err, err_sticky, syndrome, out_data[72:0]}, '0);
  endtask

  task automatic t_stream();
    cur_req = "R1";
    flt_sel = 3'd7; flt_mask = '0;
    for (int i = 0; i < 24; i++) drive(rnd8(), rnd8(), rnd8(), rnd8());
    drain();
  endtask

  task automatic t_latency();
    cur_req = "R9";
    drive(3, -5, 17, 100);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R9", "valid one cycle after", {79'd0, out_valid}, 80'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R9", "valid two cycles after", {79'd0, out_valid}, 80'd1);
    drain();
  endtask

  task automatic t_gaps();
    logic [4*OW-1:0] held;
    cur_req = "R2";
    for (int i = 0; i < 8; i++) begin
      drive(rnd8(), rnd8(), rnd8(), rnd8());
      idle(3 + i % 3);
      held = out_data;
      idle(2);
      chk(out_data === held, "R2", "lanes held while idle", out_data, held);
    end
    drain();
  endtask

  task automatic t_extreme();
    cur_req = "R3";
    for (int i = 0; i < 5; i++) drive(-128, -128, -128, -128);
    for (int i = 0; i < 5; i++) drive(127, 127, 127, 127);
    for (int i = 0; i < 8; i++)
      if (i % 2 == 0) drive(127, -128, 127, -128);
      else drive(-128, 127, -128, 127);
    drain();
  endtask

  task automatic run_fault(input logic [2:0] s, input string req);
    logic [OW-1:0] masks [3];
    masks = '{20'h00001, 20'h80000, 20'h5A3C6};
    for (int m = 0; m < 3; m++) begin
      cur_req = req;
      flt_sel = s;
      flt_mask = masks[m];
      for (int i = 0; i < 6; i++) drive(rnd8(), rnd8(), rnd8(), rnd8());
      drive(-128, 127, -128, 127);
      drain();
    end
    flt_mask = '0;
    flt_sel = 3'd7;
  endtask

  task automatic t_data_fault();
    run_fault(3'd0, "R5");
    run_fault(3'd1, "R5");
    run_fault(3'd2, "R5");
    run_fault(3'd3, "R5");
  endtask

  task automatic t_par_fault();
    run_fault(3'd4, "R6");
    run_fault(3'd5, "R6");
    run_fault(3'd6, "R6");
    run_fault(3'd7, "R6");
  endtask

  task automatic t_sticky();
    do_reset();
    cur_req = "R4";
    for (int i = 0; i < 4; i++) drive(rnd8(), rnd8(), rnd8(), rnd8());
    drain();
    chk(err_sticky == 1'b0, "R7", "sticky low with no fault", {79'd0, err_sticky}, 80'd0);
    cur_req = "R7";
    flt_sel = 3'd2; flt_mask = 20'h00010;
    drive(10, 20, 30, 40);
    drain();
    flt_sel = 3'd7; flt_mask = '0;
    for (int i = 0; i < 4; i++) drive(rnd8(), rnd8(), rnd8(), rnd8());
    drain();
    chk(out_err == 1'b0 && err_sticky == 1'b1, "R7", "sticky kept, per-sample flag clear",
        {78'd0, err_sticky, out_err}, 80'd2);
    do_reset();
    chk(err_sticky == 1'b0, "R7", "sticky cleared by reset", {79'd0, err_sticky}, 80'd0);
  endtask

  initial begin
    for (int ch = 0; ch < 4; ch++)
      for (int k = 0; k < 4; k++) hist[ch][k] = 0;
    do_reset();
    t_stream();
    t_latency();
    t_gaps();
    t_extreme();
    t_data_fault();
    t_par_fault();
    t_sticky();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R9 act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule